// File: doc/BRIEF.md
# Receive Buffer with Tide Events

A receive buffer placed between a producing peripheral and a consuming host. The peripheral pushes one word into storage per write strobe. The host does not pop words one at a time. It reads any storage slot directly by address through a combinational read port. When it has finished with some data it releases the space in one operation, in one of two ways. It can load the read pointer with the current write pointer, which empties the buffer. Or it can advance the read pointer by the number of words it consumed. An advance larger than the stored count is clamped to the write pointer, and a sticky error bit records it.

Two tide modes set how the host learns that work is waiting. In FIFO mode the tide flag is a level comparison of the stored count against a programmable tide level. In block mode the storage is treated as a ring of power-of-two blocks. The tide flag shows that at least one whole block is stored, and a tide event pulses each time the write position lands on a block boundary. An empty flag and its rising-edge event are provided in both modes. The asynchronous reset is released through a two-stage synchronizer.

Top module: `rxbuf_tide`

## Requirements
- R1: A write strobe while the buffer is not full stores the data at storage slot `wr_ptr_o[ADDR_W-1:0]` and increments `wr_ptr_o` by one. `rd_data_o` always shows the storage slot selected by `rd_addr_i`, in the same cycle.
- R2: `level_o` equals `wr_ptr_o - rd_ptr_o` modulo 2^(ADDR_W+1). `empty_o` is 1 exactly when the level is 0, and `full_o` is 1 exactly when the level is 2^ADDR_W.
- R3: A write strobe while full leaves the pointers and storage unchanged and sets `ovf_o`. `ovf_o` stays set until a cycle with `sticky_clr_i`=1 and no new overflow.
- R4: A release with `rel_op_i`=1 (load) sets `rd_ptr_o` to the value `wr_ptr_o` had before the same clock edge.
- R5: A release with `rel_op_i`=0 (advance) and `rel_cnt_i` no greater than the level adds `rel_cnt_i` to `rd_ptr_o`.
- R6: An advance with `rel_cnt_i` greater than the level sets `rd_ptr_o` to the pre-edge `wr_ptr_o` and sets the sticky `rel_err_o`, which is cleared like `ovf_o`.
- R7: With `mode_i`=0 (FIFO), `tide_o` is 1 exactly when the level is less than or equal to `tide_lvl_i`.
- R8: With `mode_i`=1 (block), the block length is 2^b words, where b is `blk_log2_i` clamped to ADDR_W. `tide_o` is 1 exactly when the level is at least one block.
- R9: `empty_ev_o` is a one-cycle pulse in the first cycle in which `empty_o` is 1 after a cycle in which it was 0. In FIFO mode, `tide_ev_o` pulses the same way on a rise of `tide_o`.
- R10: In block mode, `tide_ev_o` pulses for one cycle after an accepted write that leaves the low b bits of `wr_ptr_o` all zero.
- R11: After reset, both pointers are 0, `empty_o`=1, `full_o`=0, `ovf_o`=0, `rel_err_o`=0, and neither event output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Peripheral write strobe |
| wr_data_i | input | DATA_W | Word to store |
| rd_addr_i | input | ADDR_W | Host direct-read slot |
| rd_data_o | output | DATA_W | Contents of the selected slot |
| mode_i | input | 1 | 0 = FIFO tide level, 1 = block tide |
| tide_lvl_i | input | ADDR_W+1 | FIFO-mode tide level |
| blk_log2_i | input | BLW | Block length exponent |
| rel_en_i | input | 1 | Release request |
| rel_op_i | input | 1 | 0 = advance by count, 1 = load write pointer |
| rel_cnt_i | input | ADDR_W+1 | Words released by an advance |
| sticky_clr_i | input | 1 | Clears the overflow and release-error bits |
| wr_ptr_o | output | ADDR_W+1 | Write pointer including wrap bit |
| rd_ptr_o | output | ADDR_W+1 | Read pointer including wrap bit |
| level_o | output | ADDR_W+1 | Stored word count |
| empty_o | output | 1 | No unread data |
| full_o | output | 1 | No free slot |
| tide_o | output | 1 | Tide level flag |
| empty_ev_o | output | 1 | Empty rising-edge pulse |
| tide_ev_o | output | 1 | Tide event pulse |
| ovf_o | output | 1 | Sticky write-while-full flag |
| rel_err_o | output | 1 | Sticky over-release flag |

## Verification
If a pointer holds a wrong value, the error shows on `wr_ptr_o`, `rd_ptr_o` and `level_o` in the cycle right after the faulty edge. Because the bench compares the level against its own model on every cycle, a single lost or doubled increment is reported at once. A flag register that misses an edge shows as a missing or extra pulse on `empty_ev_o` or `tide_ev_o` in that same following cycle. Corrupted storage is exposed as soon as the host reads the slot back through `rd_data_o`.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef enum logic {
    MODE_FIFO  = 1'b0,
    MODE_BLOCK = 1'b1
  } buf_mode_e;

  typedef enum logic {
    REL_ADVANCE = 1'b0,
    REL_LOAD    = 1'b1
  } rel_op_e;
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage is not reset; the host only reads slots it knows were written
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxbuf_ptrs.sv
module rxbuf_ptrs
  import rxbuf_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int PW = ADDR_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rel_en,
  input  rel_op_e       rel_op,
  input  logic [PW-1:0] rel_cnt,
  input  logic          sticky_clr,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          accept,
  output logic [PW-1:0] wr_ptr_inc,
  output logic          ovf,
  output logic          rel_err
);
  localparam logic [PW-1:0] DEPTH = PW'(1) << ADDR_W;

  logic [PW-1:0] wr_ptr_q, rd_ptr_q, rd_ptr_d;
  logic          ovf_q, ovf_d, err_q, err_d, clamp;

  assign level      = wr_ptr_q - rd_ptr_q;
  assign full       = (level == DEPTH);
  assign empty      = (level == '0);
  assign accept     = wr_en & ~full;
  assign wr_ptr_inc = wr_ptr_q + PW'(1);

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    clamp    = 1'b0;
    if (rel_en) begin
      if (rel_op == REL_LOAD) begin
        rd_ptr_d = wr_ptr_q;
      end else if (rel_cnt > level) begin
        rd_ptr_d = wr_ptr_q;
        clamp    = 1'b1;
      end else begin
        rd_ptr_d = rd_ptr_q + rel_cnt;
      end
    end
    ovf_d = (ovf_q & ~sticky_clr) | (wr_en & full);
    err_d = (err_q & ~sticky_clr) | clamp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      ovf_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (accept) wr_ptr_q <= wr_ptr_inc;
      if (rel_en) rd_ptr_q <= rd_ptr_d;
      ovf_q <= ovf_d;
      err_q <= err_d;
    end
  end

  assign wr_ptr  = wr_ptr_q;
  assign rd_ptr  = rd_ptr_q;
  assign ovf     = ovf_q;
  assign rel_err = err_q;
endmodule

// File: rtl/rxbuf_events.sv
module rxbuf_events
  import rxbuf_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int PW  = ADDR_W + 1,
  localparam int BLW = $clog2(ADDR_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  buf_mode_e      mode,
  input  logic [PW-1:0]  level,
  input  logic           empty,
  input  logic           accept,
  input  logic [PW-1:0]  wr_ptr_inc,
  input  logic [PW-1:0]  tide_lvl,
  input  logic [BLW-1:0] blk_log2,
  output logic           tide,
  output logic           empty_ev,
  output logic           tide_ev
);
  logic [BLW-1:0] blk_eff;
  logic [PW-1:0]  blk_size, blk_mask;
  logic           boundary, blk_ev_d;
  logic           empty_q, tide_q, blk_ev_q;

  always_comb begin
    blk_eff  = (blk_log2 > BLW'(ADDR_W)) ? BLW'(ADDR_W) : blk_log2;
    blk_size = PW'(1) << blk_eff;
    blk_mask = blk_size - PW'(1);
    boundary = ((wr_ptr_inc & blk_mask) == '0);
    blk_ev_d = accept & boundary;
    if (mode == MODE_BLOCK) tide = (level >= blk_size);
    else                    tide = (level <= tide_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q  <= 1'b1;
      tide_q   <= 1'b1;
      blk_ev_q <= 1'b0;
    end else begin
      empty_q  <= empty;
      tide_q   <= tide;
      blk_ev_q <= blk_ev_d;
    end
  end

  assign empty_ev = empty & ~empty_q;
  assign tide_ev  = (mode == MODE_BLOCK) ? blk_ev_q : (tide & ~tide_q);
endmodule

// File: rtl/rxbuf_tide.sv
module rxbuf_tide
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  localparam int PW  = ADDR_W + 1,
  localparam int BLW = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              mode_i,
  input  logic [PW-1:0]     tide_lvl_i,
  input  logic [BLW-1:0]    blk_log2_i,
  input  logic              rel_en_i,
  input  logic              rel_op_i,
  input  logic [PW-1:0]     rel_cnt_i,
  input  logic              sticky_clr_i,
  output logic [PW-1:0]     wr_ptr_o,
  output logic [PW-1:0]     rd_ptr_o,
  output logic [PW-1:0]     level_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              tide_o,
  output logic              empty_ev_o,
  output logic              tide_ev_o,
  output logic              ovf_o,
  output logic              rel_err_o
);
  logic          rst_q1, rst_sync_n;
  logic          accept;
  logic [PW-1:0] wr_ptr_inc;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  rxbuf_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en_i),
    .rel_en     (rel_en_i),
    .rel_op     (rel_op_e'(rel_op_i)),
    .rel_cnt    (rel_cnt_i),
    .sticky_clr (sticky_clr_i),
    .wr_ptr     (wr_ptr_o),
    .rd_ptr     (rd_ptr_o),
    .level      (level_o),
    .full       (full_o),
    .empty      (empty_o),
    .accept     (accept),
    .wr_ptr_inc (wr_ptr_inc),
    .ovf        (ovf_o),
    .rel_err    (rel_err_o)
  );

  rxbuf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (accept),
    .waddr (wr_ptr_o[ADDR_W-1:0]),
    .wdata (wr_data_i),
    .raddr (rd_addr_i),
    .rdata (rd_data_o)
  );

  rxbuf_events #(.ADDR_W(ADDR_W)) u_events (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode       (buf_mode_e'(mode_i)),
    .level      (level_o),
    .empty      (empty_o),
    .accept     (accept),
    .wr_ptr_inc (wr_ptr_inc),
    .tide_lvl   (tide_lvl_i),
    .blk_log2   (blk_log2_i),
    .tide       (tide_o),
    .empty_ev   (empty_ev_o),
    .tide_ev    (tide_ev_o)
  );
endmodule

// File: rtl/rxbuf_tide_chk.sv
module rxbuf_tide_chk #(
  parameter int ADDR_W = 6,
  localparam int PW = ADDR_W + 1
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          wr_en,
  input logic          rel_en,
  input logic          rel_op,
  input logic [PW-1:0] rel_cnt,
  input logic          sticky_clr,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          ovf,
  input logic          rel_err,
  input logic          empty_ev
);
  localparam logic [PW-1:0] DEPTH = PW'(1) << ADDR_W;

  a_r1_write_advances: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && !full |=> wr_ptr == PW'($past(wr_ptr) + PW'(1)));

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_sync_n)
    level <= DEPTH);

  a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && full |=> wr_ptr == $past(wr_ptr) && ovf);

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf && !sticky_clr |=> ovf);

  a_r4_load_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rel_en && rel_op |=> rd_ptr == $past(wr_ptr));

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rel_en && !rel_op && rel_cnt <= level |=> rd_ptr == PW'($past(rd_ptr) + $past(rel_cnt)));

  a_r6_clamp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rel_en && !rel_op && rel_cnt > level |=> rd_ptr == $past(wr_ptr) && rel_err);

  a_r9_empty_ev_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    empty_ev |-> empty ##1 !empty_ev);
endmodule

bind rxbuf_tide rxbuf_tide_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en_i),
  .rel_en     (rel_en_i),
  .rel_op     (rel_op_i),
  .rel_cnt    (rel_cnt_i),
  .sticky_clr (sticky_clr_i),
  .wr_ptr     (wr_ptr_o),
  .rd_ptr     (rd_ptr_o),
  .level      (level_o),
  .full       (full_o),
  .empty      (empty_o),
  .ovf        (ovf_o),
  .rel_err    (rel_err_o),
  .empty_ev   (empty_ev_o)
);

// File: tb/sim_rxbuf_tide.sv
module sim_rxbuf_tide;
  localparam int PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int PW = AW + 1;
  localparam int BLW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rel_en = 1'b0, rel_op = 1'b0, sclr = 1'b0, mode = 1'b0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [AW-1:0] rd_addr = '0;
  logic [PW-1:0] tide_lvl = '0, rel_cnt = '0;
  logic [BLW-1:0] blk_log2 = '0;
  logic [PW-1:0] wr_ptr, rd_ptr, level;
  logic empty, full, tide, empty_ev, tide_ev, ovf, rel_err;

  int checks = 0, errors = 0;

  // bench model
  int unsigned m_wr = 0, m_rd = 0;
  logic [DW-1:0] m_mem [DEPTH];
  bit m_vld [DEPTH];
  bit m_ovf = 0, m_err = 0, m_eev = 0, m_tev = 0;
  string rel_tag = "R5";

  always #(PERIOD/2) clk = ~clk;

  rxbuf_tide #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .mode_i(mode),
    .tide_lvl_i(tide_lvl), .blk_log2_i(blk_log2), .rel_en_i(rel_en),
    .rel_op_i(rel_op), .rel_cnt_i(rel_cnt), .sticky_clr_i(sclr),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .level_o(level), .empty_o(empty),
    .full_o(full), .tide_o(tide), .empty_ev_o(empty_ev), .tide_ev_o(tide_ev),
    .ovf_o(ovf), .rel_err_o(rel_err)
  );

  function automatic int blk_len(input int b);
    return 1 << ((b > AW) ? AW : b);
  endfunction

  function automatic bit f_tide(input bit md, input int cnt, input int lvl, input int b);
    if (md) return cnt >= blk_len(b);   // R8
    return cnt <= lvl;                  // R7
  endfunction

  function automatic int m_level();
    return int'((m_wr - m_rd) % (2 * DEPTH));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int lv = m_level();
    chk("R1 wr_ptr", int'(wr_ptr), int'(m_wr % (2 * DEPTH)));
    chk({rel_tag, " rd_ptr"}, int'(rd_ptr), int'(m_rd % (2 * DEPTH)));
    chk("R2 level", int'(level), lv);
    chk("R2 empty", int'(empty), int'(lv == 0));
    chk("R2 full", int'(full), int'(lv == DEPTH));
    chk(mode ? "R8 tide" : "R7 tide", int'(tide),
        int'(f_tide(mode, lv, int'(tide_lvl), int'(blk_log2))));
    chk("R9 empty_ev", int'(empty_ev), int'(m_eev));
    chk(mode ? "R10 tide_ev" : "R9 tide_ev", int'(tide_ev), int'(m_tev));
    chk("R3 ovf", int'(ovf), int'(m_ovf));
    chk("R6 rel_err", int'(rel_err), int'(m_err));
    if (m_vld[rd_addr]) chk("R1 rd_data", int'(rd_data), int'(m_mem[rd_addr]));
  endtask

  // drive at a falling edge, update the model, check at the next falling edge
  task automatic step(input bit w, input bit re, input bit op, input int cnt,
                      input bit clr);
    int lv0 = m_level();
    bit full0 = (lv0 == DEPTH);
    bit acc = w && !full0;
    bit prev_tide = f_tide(mode, lv0, int'(tide_lvl), int'(blk_log2));
    bit prev_empty = (lv0 == 0);
    bit clamp = 0;
    int unsigned wr_old = m_wr;
    int lv1;
    wr_en = w; wr_data = DW'($urandom); rel_en = re; rel_op = op;
    rel_cnt = PW'(cnt); sclr = clr; rd_addr = AW'($urandom);
    if (acc) begin
      m_mem[m_wr % DEPTH] = wr_data;
      m_vld[m_wr % DEPTH] = 1;
      m_wr = m_wr + 1;
    end
    if (re) begin
      if (op) begin m_rd = wr_old; rel_tag = "R4"; end
      else if (cnt > lv0) begin m_rd = wr_old; clamp = 1; rel_tag = "R6"; end
      else begin m_rd = m_rd + cnt; rel_tag = "R5"; end
    end
    m_ovf = (m_ovf && !clr) || (w && full0);
    m_err = (m_err && !clr) || clamp;
    lv1 = m_level();
    m_eev = (lv1 == 0) && !prev_empty;
    if (mode) m_tev = acc && ((m_wr % blk_len(int'(blk_log2))) == 0);
    else      m_tev = f_tide(mode, lv1, int'(tide_lvl), int'(blk_log2)) && !prev_tide;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rel_en = 0; sclr = 0;
    check_all();
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    mode = 0; tide_lvl = PW'(4); blk_log2 = 3'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 wr_ptr", int'(wr_ptr), 0);
    chk("R11 rd_ptr", int'(rd_ptr), 0);
    chk("R11 empty", int'(empty), 1);
    chk("R11 full", int'(full), 0);
    chk("R11 ovf", int'(ovf), 0);
    chk("R11 rel_err", int'(rel_err), 0);
    chk("R11 events", int'(empty_ev | tide_ev), 0);

    // directed: fill to full (R1, R2, tide fall in R7), then overflow (R3)
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // ovf stays until cleared
    step(0, 0, 0, 0, 1);
    // R4: load release empties in one step; R9 empty event and tide rise
    step(0, 1, 1, 0, 0);
    // R5: advance by count
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0);
    step(0, 1, 0, 7, 0);
    step(0, 1, 0, 3, 0);
    // R6: over-release clamps, then clear
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0);
    step(1, 1, 0, 20, 0);
    step(0, 0, 0, 0, 1);

    // random FIFO mode with several tide levels
    for (int ph = 0; ph < 3; ph++) begin
      tide_lvl = PW'($urandom_range(0, DEPTH));
      for (int i = 0; i < 1500; i++) begin
        bit re = ($urandom_range(0, 99) < 15);
        step($urandom_range(0, 99) < 60, re, $urandom_range(0, 4) == 0,
             $urandom_range(0, 14), $urandom_range(0, 49) == 0);
      end
    end

    // block mode, several block sizes including a clamped exponent (R8, R10)
    mode = 1;
    for (int b = 0; b < 8; b++) begin
      blk_log2 = BLW'(b);
      for (int i = 0; i < 800; i++) begin
        bit re = ($urandom_range(0, 99) < 12);
        step($urandom_range(0, 99) < 70, re, $urandom_range(0, 3) == 0,
             $urandom_range(0, 16), $urandom_range(0, 49) == 0);
      end
    end
    // directed block crossing: empty, then exactly one block of 8
    blk_log2 = 3'd3;
    step(0, 1, 1, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule